// File: doc/BRIEF.md
# Transmit Descriptor and Completion Ring Engine

This block is the memory-side half of a transmit path. Software places two-word transmit descriptors in a ring in memory, reserves a second ring for one-word completion records, and tells the engine how much new work exists by writing a count. The engine then works through that count one entry at a time. For each entry it reads the descriptor over a simple request/grant memory port, passes the frame request to the MAC through a valid/ready handshake, and waits for the MAC's result. It then writes a completion word into the status ring and sets a transmit interrupt flag.

The two rings have independent base, length and current-address registers, so their pointers wrap on their own schedules. A descriptor marked for abort never reaches the MAC. It is still completed with a status word, so software sees every entry come back. A global enable bit in a control register decides whether the engine may start new entries. The transmit interrupt flag can be read plainly or through a read-to-clear alias, and it reaches the interrupt line only when its enable bit is set.

Top module: `txq_engine`

## Requirements
- R1: A descriptor is read as two words. The first word is read at the descriptor current address and holds the buffer address. The second word is read at current address + 4. In that second word, bit 31 is end of frame, bits 30:16 are the buffer index, bit 15 is abort and bits 11:0 are the byte length. A non-aborted descriptor is presented on the MAC outputs with mac_valid held, and the request kept stable, until mac_ready.
- R2: The completion word has these fields. Bit 31 is processed and is always 1. Bit 30 means sent without error, bit 29 means aborted, bit 26 is the late-collision flag, bit 25 is the underrun flag and bit 24 is the excessive-collision flag. Bits 20:16 carry the collision count and bits 14:0 carry the descriptor's buffer index. All other bits are 0. The error and count fields come from the MAC result reported with mac_done.
- R3: A descriptor with bit 15 set is never presented to the MAC. Its completion word is 0xA0000000 OR the buffer index: processed and aborted set, no-error clear, all result fields 0.
- R4: The descriptor pointer advances by 8 after each descriptor is read. The status pointer advances by 4 after each completion write. Each pointer returns to its own base when it reaches base + length, independently of the other.
- R5: A write of N to the enqueue register adds N to the pending count, including while the engine is busy. Each completion write removes one. The engine starts a new entry only while the pending count is nonzero.
- R6: The engine starts no new entry, and makes no memory request, while control bit 8 (enable) is 0.
- R7: Interrupt status bit 3 is set in the clock after a completion write is granted. A read of the read-to-clear alias clears it in the following clock; a plain read leaves it unchanged, and a set in the same clock wins over a clear. The irq output equals status bit 3 AND interrupt-enable bit 3.
- R8: The register selects are: 0 descriptor base, 1 descriptor ring length in bytes, 2 descriptor current address, 3 status base, 4 status ring length in bytes, 5 status current address, 6 enqueue (reads back the pending count), 7 control, 8 interrupt enable, 9 interrupt status, 10 interrupt status read-to-clear. Writing a base also loads that ring's current address, and all registers reset to 0.
- R9: A memory request holds its address, direction and write data until mem_grant. Each grant moves exactly one 32-bit word, and read data is taken from mem_rdata in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the read-to-clear alias) |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| irq | output | 1 | Transmit interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes one word |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| mac_valid | output | 1 | Frame request valid |
| mac_ready | input | 1 | MAC accepts the frame request |
| mac_addr | output | 32 | Frame buffer address |
| mac_len | output | 12 | Frame byte length |
| mac_eof | output | 1 | End-of-frame flag |
| mac_index | output | 15 | Buffer index |
| mac_done | input | 1 | MAC result strobe |
| mac_ok | input | 1 | Frame sent without error |
| mac_late_coll | input | 1 | Late collision seen |
| mac_underrun | input | 1 | Transmit underrun seen |
| mac_excess_coll | input | 1 | Excessive collisions seen |
| mac_coll_cnt | input | 5 | Collision count |

## Verification
A frame request is due on the MAC outputs and is compared in the same cycle that the handshake completes. A completion word is compared, with its address, in the cycle its write is granted. The interrupt flag and the irq line are due one clock after that grant, and a read-to-clear read takes effect one clock after the read. The bench drives its inputs just after each rising edge and compares at the falling edge. Its reference model updates its flag and enable state at the rising edge from the port activity it saw at the preceding falling edge, so every comparison sees exactly the registered state the requirements predict. The expected descriptor and completion sequences are built from the bench's own memory image and its own wrapping pointers at enqueue time.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;

    localparam int WORD_W    = 32;
    localparam int FLEN_W    = 12;
    localparam int IDX_W     = 15;
    localparam int ABORT_BIT = 15;
    localparam int EN_BIT    = 8;
    localparam int TXINT_BIT = 3;

    typedef enum logic [3:0] {
        SEL_DBASE = 4'd0,
        SEL_DLEN  = 4'd1,
        SEL_DCUR  = 4'd2,
        SEL_SBASE = 4'd3,
        SEL_SLEN  = 4'd4,
        SEL_SCUR  = 4'd5,
        SEL_ENQ   = 4'd6,
        SEL_CTRL  = 4'd7,
        SEL_IEN   = 4'd8,
        SEL_ISTS  = 4'd9,
        SEL_ICLR  = 4'd10
    } txq_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] buf_addr;
        logic              eof;
        logic [IDX_W-1:0]  idx;
        logic              abort;
        logic [FLEN_W-1:0] len;
    } txq_desc_t;

    typedef struct packed {
        logic       ok;
        logic       late_coll;
        logic       underrun;
        logic       excess_coll;
        logic [4:0] coll_cnt;
    } txq_result_t;

    // Fill the control fields of a descriptor from its second word.
    function automatic txq_desc_t take_ctl(input txq_desc_t d, input logic [WORD_W-1:0] w);
        txq_desc_t r;
        r       = d;
        r.eof   = w[31];
        r.idx   = w[30:16];
        r.abort = w[ABORT_BIT];
        r.len   = w[FLEN_W-1:0];
        return r;
    endfunction

    // Assemble one completion word.
    function automatic logic [WORD_W-1:0] make_status(input logic aborted,
                                                      input txq_result_t res,
                                                      input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] s;
        s        = '0;
        s[31]    = 1'b1;
        s[30]    = res.ok & ~aborted;
        s[29]    = aborted;
        s[26]    = res.late_coll;
        s[25]    = res.underrun;
        s[24]    = res.excess_coll;
        s[20:16] = res.coll_cnt;
        s[14:0]  = idx;
        return s;
    endfunction

endpackage

// File: rtl/txq_ring_ptr.sv
`timescale 1ns/1ps
module txq_ring_ptr #(
    parameter int RLEN_W = 16,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [31:0]       load_val,
    input  logic              step,
    input  logic [31:0]       base,
    input  logic [RLEN_W-1:0] len,
    output logic [31:0]       cur
);
    localparam logic [31:0] STEP_W = 32'(STEP);

    logic [31:0] nxt;
    logic [31:0] lim;

    assign nxt = cur + STEP_W;
    assign lim = base + 32'(len);

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (load)
            cur <= load_val;
        else if (step)
            cur <= (nxt >= lim) ? base : nxt;
    end

    // After a step the pointer is either one entry further or back at base.
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cur == $past(base)) || (cur == $past(cur) + STEP_W));

endmodule

// File: rtl/txq_regs.sv
`timescale 1ns/1ps
module txq_regs
    import txq_pkg::*;
#(
    parameter int RLEN_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       desc_cur,
    input  logic [31:0]       stat_cur,
    input  logic              entry_done,
    output logic [31:0]       desc_base,
    output logic [RLEN_W-1:0] desc_len,
    output logic [31:0]       stat_base,
    output logic [RLEN_W-1:0] stat_len,
    output logic              desc_load,
    output logic              stat_load,
    output logic              run,
    output logic              irq
);
    txq_sel_e         sel;
    logic [CNT_W-1:0] pending;
    logic [CNT_W-1:0] add_cnt;
    logic             enable;
    logic             int_en;
    logic             int_sts;
    logic             enq_wr;

    assign sel       = txq_sel_e'(reg_sel);
    assign enq_wr    = reg_wr && (sel == SEL_ENQ);
    assign add_cnt   = enq_wr ? reg_wdata[CNT_W-1:0] : '0;
    assign desc_load = reg_wr && (sel == SEL_DBASE || sel == SEL_DCUR);
    assign stat_load = reg_wr && (sel == SEL_SBASE || sel == SEL_SCUR);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_base <= '0;
            desc_len  <= '0;
            stat_base <= '0;
            stat_len  <= '0;
            enable    <= 1'b0;
            int_en    <= 1'b0;
        end else if (reg_wr) begin
            case (sel)
                SEL_DBASE: desc_base <= reg_wdata;
                SEL_DLEN:  desc_len  <= reg_wdata[RLEN_W-1:0];
                SEL_SBASE: stat_base <= reg_wdata;
                SEL_SLEN:  stat_len  <= reg_wdata[RLEN_W-1:0];
                SEL_CTRL:  enable    <= reg_wdata[EN_BIT];
                SEL_IEN:   int_en    <= reg_wdata[TXINT_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending <= '0;
        else
            pending <= pending + add_cnt - CNT_W'(entry_done);
    end

    always_ff @(posedge clk) begin
        if (rst)
            int_sts <= 1'b0;
        else if (entry_done)
            int_sts <= 1'b1;
        else if (reg_rd && sel == SEL_ICLR)
            int_sts <= 1'b0;
    end

    assign run = enable && (pending != '0);
    assign irq = int_sts && int_en;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_DBASE: reg_rdata = desc_base;
            SEL_DLEN:  reg_rdata = 32'(desc_len);
            SEL_DCUR:  reg_rdata = desc_cur;
            SEL_SBASE: reg_rdata = stat_base;
            SEL_SLEN:  reg_rdata = 32'(stat_len);
            SEL_SCUR:  reg_rdata = stat_cur;
            SEL_ENQ:   reg_rdata = 32'(pending);
            SEL_CTRL:  reg_rdata[EN_BIT] = enable;
            SEL_IEN:   reg_rdata[TXINT_BIT] = int_en;
            SEL_ISTS,
            SEL_ICLR:  reg_rdata[TXINT_BIT] = int_sts;
            default:   reg_rdata = '0;
        endcase
    end

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (pending != '0));

    assert_pending_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (entry_done && !enq_wr) |=> (pending == $past(pending) - 1'b1));

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> int_sts);

endmodule

// File: rtl/txq_ctrl.sv
`timescale 1ns/1ps
module txq_ctrl
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [31:0]       desc_cur,
    input  logic [31:0]       stat_cur,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic              mac_valid,
    input  logic              mac_ready,
    output logic [31:0]       mac_addr,
    output logic [FLEN_W-1:0] mac_len,
    output logic              mac_eof,
    output logic [IDX_W-1:0]  mac_index,
    input  logic              mac_done,
    input  txq_result_t       mac_res,
    output logic              desc_step,
    output logic              entry_done
);
    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_SEND, S_WAIT, S_WST
    } txq_state_e;

    txq_state_e  state;
    txq_desc_t   desc_q;
    txq_result_t res_q;
    logic        mem_rdata_unused;

    assign mem_rdata_unused = ^mem_rdata[14:12];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            desc_q <= '0;
            res_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (run) state <= S_RD0;
                S_RD0: if (mem_gnt) begin
                    desc_q.buf_addr <= mem_rdata;
                    state           <= S_RD1;
                end
                S_RD1: if (mem_gnt) begin
                    desc_q <= take_ctl(desc_q, mem_rdata);
                    res_q  <= '0;
                    state  <= mem_rdata[ABORT_BIT] ? S_WST : S_SEND;
                end
                S_SEND: if (mac_ready) state <= S_WAIT;
                S_WAIT: if (mac_done) begin
                    res_q <= mac_res;
                    state <= S_WST;
                end
                S_WST: if (mem_gnt) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_cur;
        mem_wdata = '0;
        case (state)
            S_RD0: mem_req = 1'b1;
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = desc_cur + 32'd4;
            end
            S_WST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_cur;
                mem_wdata = make_status(desc_q.abort, res_q, desc_q.idx);
            end
            default: ;
        endcase
    end

    assign mac_valid  = (state == S_SEND);
    assign mac_addr   = desc_q.buf_addr;
    assign mac_len    = desc_q.len;
    assign mac_eof    = desc_q.eof;
    assign mac_index  = desc_q.idx;
    assign desc_step  = (state == S_RD1) && mem_gnt;
    assign entry_done = (state == S_WST) && mem_gnt;

    assert_mac_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mac_valid && !mac_ready) |=> mac_valid && $stable(mac_addr)
                                      && $stable(mac_index) && $stable(mac_len));

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !run) |=> !mem_req);

    assert_abort_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD1 && mem_gnt && mem_rdata[ABORT_BIT]) |=> (!mac_valid && mem_we));

    assert_one_user_R9: assert property (@(posedge clk) disable iff (rst)
        !(mac_valid && mem_req));

endmodule

// File: rtl/txq_engine.sv
`timescale 1ns/1ps
module txq_engine
    import txq_pkg::*;
#(
    parameter int RLEN_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata,
    output logic        mac_valid,
    input  logic        mac_ready,
    output logic [31:0] mac_addr,
    output logic [11:0] mac_len,
    output logic        mac_eof,
    output logic [14:0] mac_index,
    input  logic        mac_done,
    input  logic        mac_ok,
    input  logic        mac_late_coll,
    input  logic        mac_underrun,
    input  logic        mac_excess_coll,
    input  logic [4:0]  mac_coll_cnt
);
    localparam int DESC_BYTES = 8;
    localparam int STAT_BYTES = 4;

    logic [31:0]       desc_base, stat_base, desc_cur, stat_cur;
    logic [RLEN_W-1:0] desc_len, stat_len;
    logic              desc_load, stat_load, desc_step, entry_done, run;
    txq_result_t       mac_res;

    assign mac_res = '{ok: mac_ok, late_coll: mac_late_coll, underrun: mac_underrun,
                       excess_coll: mac_excess_coll, coll_cnt: mac_coll_cnt};

    txq_regs #(.RLEN_W(RLEN_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_cur(desc_cur),
        .stat_cur(stat_cur), .entry_done(entry_done), .desc_base(desc_base),
        .desc_len(desc_len), .stat_base(stat_base), .stat_len(stat_len),
        .desc_load(desc_load), .stat_load(stat_load), .run(run), .irq(irq)
    );

    txq_ring_ptr #(.RLEN_W(RLEN_W), .STEP(DESC_BYTES)) u_desc_ptr (
        .clk(clk), .rst(rst), .load(desc_load), .load_val(reg_wdata), .step(desc_step),
        .base(desc_base), .len(desc_len), .cur(desc_cur)
    );

    txq_ring_ptr #(.RLEN_W(RLEN_W), .STEP(STAT_BYTES)) u_stat_ptr (
        .clk(clk), .rst(rst), .load(stat_load), .load_val(reg_wdata), .step(entry_done),
        .base(stat_base), .len(stat_len), .cur(stat_cur)
    );

    txq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .run(run), .desc_cur(desc_cur), .stat_cur(stat_cur),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mac_valid(mac_valid),
        .mac_ready(mac_ready), .mac_addr(mac_addr), .mac_len(mac_len), .mac_eof(mac_eof),
        .mac_index(mac_index), .mac_done(mac_done), .mac_res(mac_res),
        .desc_step(desc_step), .entry_done(entry_done)
    );

endmodule

// File: tb/test_txq_engine.sv
`timescale 1ns/1ps
module test_txq_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mac_valid, mac_ready, mac_eof, mac_done;
    logic [31:0] mac_addr;
    logic [11:0] mac_len;
    logic [14:0] mac_index;
    logic        mac_ok, mac_late_coll, mac_underrun, mac_excess_coll;
    logic [4:0]  mac_coll_cnt;

    always #5 clk = ~clk;

    txq_engine i_txq_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mac_valid(mac_valid), .mac_ready(mac_ready),
        .mac_addr(mac_addr), .mac_len(mac_len), .mac_eof(mac_eof), .mac_index(mac_index),
        .mac_done(mac_done), .mac_ok(mac_ok), .mac_late_coll(mac_late_coll),
        .mac_underrun(mac_underrun), .mac_excess_coll(mac_excess_coll),
        .mac_coll_cnt(mac_coll_cnt)
    );

    int compared = 0;
    int mismatched = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Memory model: grant withheld one cycle in three.
    logic [31:0] mem [0:255];
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    assign mem_gnt   = mem_req && ((cyc % 3) != 1);
    assign mem_rdata = mem[mem_addr[9:2]];

    // MAC stub: accepts on alternate pairs of cycles, reports 3 cycles later.
    function automatic logic [8:0] res_of(input logic [14:0] ix);
        logic [4:0] c;
        c = ix[4:0] + 5'd1;
        return {ix[1:0] != 2'b11, ix[1:0] == 2'b11, ix[2], ix[3], c};
    endfunction

    logic [14:0] stub_idx;
    int          stub_cd;
    assign mac_ready = cyc[1];
    always @(posedge clk) begin
        if (rst) begin
            stub_cd  <= 0;
            stub_idx <= '0;
        end else if (mac_valid && mac_ready) begin
            stub_cd  <= 3;
            stub_idx <= mac_index;
        end else if (stub_cd > 0) begin
            stub_cd <= stub_cd - 1;
        end
    end
    assign mac_done = (stub_cd == 1);
    assign {mac_ok, mac_late_coll, mac_underrun, mac_excess_coll, mac_coll_cnt} = res_of(stub_idx);

    // Reference model state.
    logic [59:0] exp_mac [$];
    logic [63:0] exp_stat [$];
    logic        m_sts, m_ien, m_en, n_sts, n_ien, n_en;
    logic        hold_prev;
    logic [31:0] prev_addr;
    int dptr, sptr;
    localparam int DBASE = 0, DLEN = 32, SBASE = 32'h200, SLEN = 12;

    always @(posedge clk) begin
        if (rst) begin
            m_sts <= 1'b0; m_ien <= 1'b0; m_en <= 1'b0;
        end else begin
            m_sts <= n_sts; m_ien <= n_ien; m_en <= n_en;
        end
    end

    always @(negedge clk) begin
        logic [59:0] em;
        logic [63:0] es;
        logic        wgnt;
        wgnt = mem_req && mem_we && mem_gnt;
        if (!rst) begin
            if (mac_valid && mac_ready) begin
                if (exp_mac.size() == 0)
                    chk(0, "R1 unexpected frame request", {mac_addr, 17'd0, mac_index}, 64'd0);
                else begin
                    em = exp_mac.pop_front();
                    chk({mac_addr, mac_len, mac_eof, mac_index} == em, "R1 frame request",
                        64'({mac_addr, mac_len, mac_eof, mac_index}), 64'(em));
                end
            end
            if (wgnt) begin
                if (exp_stat.size() == 0)
                    chk(0, "R2 unexpected status write", {mem_addr, mem_wdata}, 64'd0);
                else begin
                    es = exp_stat.pop_front();
                    chk({mem_addr, mem_wdata} == es, "R2/R3/R4 status address and word",
                        {mem_addr, mem_wdata}, es);
                end
            end
            if (mem_req && !m_en)
                chk(0, "R6 memory request while disabled", 64'(mem_addr), 64'd0);
            if (hold_prev)
                chk(mem_req && mem_addr == prev_addr, "R9 request held until grant",
                    {31'd0, mem_req, mem_addr}, {32'd1, prev_addr});
            chk(irq == (m_sts && m_ien), "R7 irq line", 64'(irq), 64'(m_sts && m_ien));
            if (reg_rd && reg_sel == 4'd9)
                chk(reg_rdata[3] == m_sts, "R7 status read", 64'(reg_rdata[3]), 64'(m_sts));
        end
        hold_prev = !rst && mem_req && !mem_gnt;
        prev_addr = mem_addr;
        n_sts = m_sts;
        if (reg_rd && reg_sel == 4'd10) n_sts = 1'b0;
        if (wgnt) n_sts = 1'b1;
        n_ien = (reg_wr && reg_sel == 4'd8) ? reg_wdata[3] : m_ien;
        n_en  = (reg_wr && reg_sel == 4'd7) ? reg_wdata[8] : m_en;
    end

    task automatic step1();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        step1();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] d);
        reg_rd = 1'b1; reg_sel = s;
        @(negedge clk);
        d = reg_rdata;
        step1();
        reg_rd = 1'b0;
    endtask

    // Build expectations from the bench's own ring image, then enqueue.
    task automatic enq(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w0, w1, sw;
            logic [14:0] ix;
            logic [8:0]  r;
            w0 = mem[dptr / 4];
            w1 = mem[dptr / 4 + 1];
            ix = w1[30:16];
            r  = res_of(ix);
            if (!w1[15]) exp_mac.push_back({w0, w1[11:0], w1[31], ix});
            if (w1[15]) sw = 32'hA000_0000 | 32'(ix);
            else sw = {1'b1, r[8], 1'b0, 2'b00, r[7], r[6], r[5], 3'b000, r[4:0], 1'b0, ix};
            exp_stat.push_back({32'(sptr), sw});
            dptr = dptr + 8;
            if (dptr >= DBASE + DLEN) dptr = DBASE;
            sptr = sptr + 4;
            if (sptr >= SBASE + SLEN) sptr = SBASE;
        end
        wr(4'd6, 32'(n));
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while ((exp_mac.size() != 0 || exp_stat.size() != 0) && t < 2000) begin
            step1();
            t++;
        end
        chk(t < 2000, req, 64'(exp_stat.size()), 64'd0);
        repeat (5) step1();
    endtask

    initial begin
        #2_000_000;
        $display("FAIL watchdog expired");
        compared++;
        mismatched++;
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = '0; reg_wdata = '0;
        hold_prev = 1'b0; prev_addr = '0;
        dptr = DBASE; sptr = SBASE;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // Four descriptors: #1 not end of frame, #2 aborted.
        for (int i = 0; i < 4; i++) begin
            mem[2*i]     = 32'h1000_0000 + 32'(i) * 32'h100;
            mem[2*i + 1] = {(i != 1), 15'(i + 3), (i == 2), 3'b000, 12'(60 + i * 17)};
        end
        repeat (3) step1();
        rst = 1'b0;
        step1();

        // Reset state (R8, R5, R9, R1).
        rd(4'd0, v);  chk(v == 0, "R8 reset descriptor base", 64'(v), 64'd0);
        rd(4'd6, v);  chk(v == 0, "R5 reset pending count", 64'(v), 64'd0);
        chk(!mem_req, "R9 no request after reset", 64'(mem_req), 64'd0);
        chk(!mac_valid, "R1 no frame request after reset", 64'(mac_valid), 64'd0);

        // Ring setup; base writes load the current addresses.
        wr(4'd0, DBASE); wr(4'd1, DLEN); wr(4'd3, SBASE); wr(4'd4, SLEN); wr(4'd8, 32'h8);
        rd(4'd5, v);  chk(v == SBASE, "R8 base write loads current", 64'(v), 64'(SBASE));

        // Work queued while disabled must wait.
        enq(2);
        repeat (20) step1();
        chk(exp_stat.size() == 2, "R6 no progress while disabled", 64'(exp_stat.size()), 64'd2);
        rd(4'd6, v);  chk(v == 2, "R5 pending count after enqueue", 64'(v), 64'd2);
        wr(4'd7, 32'h100);
        drain("R5 first batch completes");

        // Interrupt flag: plain read keeps it, alias read clears it.
        chk(irq == 1'b1, "R7 irq after completion", 64'(irq), 64'd1);
        rd(4'd9, v);  chk(v[3] == 1'b1, "R7 status bit set", 64'(v), 64'h8);
        chk(irq == 1'b1, "R7 plain read keeps flag", 64'(irq), 64'd1);
        rd(4'd10, v);
        step1();
        chk(irq == 1'b0, "R7 alias read clears flag", 64'(irq), 64'd0);

        // Accumulating enqueue while busy; both rings wrap.
        enq(3);
        repeat (6) step1();
        enq(1);
        drain("R5 accumulated work completes");

        // Masked interrupt still records status.
        wr(4'd8, 32'h0);
        rd(4'd10, v);
        enq(1);
        drain("R5 single entry completes");
        chk(irq == 1'b0, "R7 masked irq stays low", 64'(irq), 64'd0);
        rd(4'd9, v);  chk(v[3] == 1'b1, "R7 status set while masked", 64'(v), 64'h8);

        // Final pointer positions after wrapping.
        rd(4'd2, v);  chk(v == 32'(dptr), "R4 descriptor pointer wrap", 64'(v), 64'(dptr));
        rd(4'd5, v);  chk(v == 32'(sptr), "R4 status pointer wrap", 64'(v), 64'(sptr));
        rd(4'd6, v);  chk(v == 0, "R5 pending count drained", 64'(v), 64'd0);

        summary();
        $finish;
    end

endmodule